// File: doc/BRIEF.md
# Serial Converter Host Sequencer

This block is the host-side master for one conversion on a serial, multiplexed 8-bit analog-to-digital converter. A request carries a channel select, an odd/sign bit and a single-ended/differential choice. On acceptance the block lowers chip select and produces a serial clock. Each half period of that clock lasts a programmable number of system cycles. The block then shifts out a start bit and four address bits. After that it waits out the converter's settling bit and collects the result twice: first most significant bit first, then least significant bit first.

When the frame is over, the block raises chip select while the serial clock is high. It keeps chip select high for a guard interval before it takes the next request, which lets the converter clear its internal state. The result goes out with a one-cycle valid strobe. A mismatch flag is raised when the two received copies disagree. In shared-wire mode the converter's data input and output are one line, and the block stops driving that line once the address has been sent.

Top module: `sadc_host`

## Requirements
- R1: `req_ready` is high only while no conversion or guard interval is running. A request seen with `req_valid` and `req_ready` both high drives `adc_cs_n` low on the next cycle. Request fields, `div_half` and `share_en` are captured only at acceptance. A request held during a conversion is not accepted and does not change it.
- R2: Each low and each high phase of `adc_sclk` lasts `div_half` system cycles, with 0 treated as 1. One conversion contains exactly 21 rising edges of `adc_sclk`.
- R3: `adc_di` carries five bits, one sampled at each of the first five rising edges, in this order: 1 (start), SGL = NOT `req_diff`, ODD = `req_odd`, SEL1 = `req_sel[1]`, SEL0 = `req_sel[0]`. `adc_di` changes only while `adc_sclk` is low.
- R4: `adc_do` is sampled on rising edges. The bit at edge 6 is a leading zero and is discarded. Edges 7 to 14 give result bits 7 down to 0, and those bits form `res_data`.
- R5: Edges 15 to 21 give result bits 1 up to 7 of the reversed copy. Bit 0 of that copy is the bit taken at edge 14. `res_mismatch` is 1 exactly when the reversed copy differs from `res_data`, and `res_data` is still reported in that case.
- R6: `res_valid` is a single-cycle pulse in the first cycle in which `adc_cs_n` is high again after a conversion.
- R7: `adc_sclk` is high whenever `adc_cs_n` is high, and chip select rises during a high clock phase. After chip select rises, `req_ready` returns exactly 2 x `div_half` cycles later (two half periods).
- R8: With `share_en` = 1, `adc_di_oe` goes low at the falling edge that follows the fifth rising edge and stays low until `adc_cs_n` rises. With `share_en` = 0, `adc_di_oe` stays 1 and `adc_di` is 0 after the address.
- R9: After reset, `adc_cs_n` = 1, `adc_sclk` = 1, `res_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Request can be accepted |
| req_sel | input | 2 | Channel select bits SEL1, SEL0 |
| req_odd | input | 1 | Odd/sign address bit |
| req_diff | input | 1 | 1 = differential, 0 = single-ended |
| div_half | input | DIV_W | System cycles per serial clock half period |
| share_en | input | 1 | Single shared data wire mode |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_di | output | 1 | Serial data to converter |
| adc_di_oe | output | 1 | Drive enable for adc_di |
| adc_do | input | 1 | Serial data from converter |
| res_valid | output | 1 | Result strobe |
| res_data | output | 8 | Conversion result |
| res_mismatch | output | 1 | Two received copies disagree |

## Verification
A converter model in the bench sweeps all 16 address combinations of mode, odd bit and channel. It does so in both the separate-wire and the shared-wire arrangement. Each address yields a different result value, so a wrong or reordered address bit shows up both in the decoded word and in the returned data. A corrupted reversed copy separates a correct mismatch compare from a flag that is stuck or always raised. A request held during a conversion tells apart a block that ignores it from one that restarts or re-latches. Divider values 0, 1, 3, 25 and 26 check the phase lengths, the 21-edge frame and the guard interval against the arithmetic in the bench.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    // frame layout of one conversion, counted in serial bit slots
    localparam int ADDR_LEN  = 5;
    localparam int RES_LEN   = 8;
    localparam int ZERO_BIT  = ADDR_LEN;
    localparam int FWD_FIRST = ADDR_LEN + 1;
    localparam int FWD_LAST  = ADDR_LEN + RES_LEN;
    localparam int NBITS     = ADDR_LEN + 1 + RES_LEN + (RES_LEN - 1);
    localparam int NPHASE    = 2 * NBITS;
    localparam int PH_W      = $clog2(NPHASE);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/sadc_halfclk.sv
module sadc_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] half_len,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } hc_s;

    hc_s d, q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last  = (half_len == '0) ? '0 : half_len - 1'b1;
        tick  = !clr && (q.cnt == last);
        d     = q;
        if (clr || tick) d.cnt = '0;
        else             d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: the phase counter never runs past the programmed half length
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (q.cnt <= last));
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    input  logic         to_fwd,
    input  logic         to_rev,
    output logic [W-1:0] fwd_o,
    output logic [W-1:0] rev_o
);
    typedef struct packed {
        logic [W-1:0] fwd;
        logic [W-1:0] rev;
    } cap_s;

    cap_s d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else if (shift) begin
            // forward copy arrives high bit first: enter at the bottom
            if (to_fwd) d.fwd = {q.fwd[W-2:0], bit_in};
            // reversed copy arrives low bit first: enter at the top
            if (to_rev) d.rev = {bit_in, q.rev[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fwd_o = q.fwd;
    assign rev_o = q.rev;

    // R5: while only the reversed copy is collected the forward result is frozen
    a_r5_fwd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr && to_rev && !to_fwd) |=> $stable(q.fwd));
endmodule

// File: rtl/sadc_host.sv
module sadc_host
    import sadc_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int GAP_HALVES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_sel,
    input  logic             req_odd,
    input  logic             req_diff,
    input  logic [DIV_W-1:0] div_half,
    input  logic             share_en,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    output logic             adc_di,
    output logic             adc_di_oe,
    input  logic             adc_do,
    output logic             res_valid,
    output logic [7:0]       res_data,
    output logic             res_mismatch
);
    localparam int GAP_W = $clog2(GAP_HALVES + 1);
    localparam logic [GAP_W-1:0] GAP_LAST    = GAP_W'(GAP_HALVES - 1);
    localparam logic [PH_W-1:0]  PH_LAST     = PH_W'(NPHASE - 1);
    localparam logic [PH_W-1:0]  K_ZERO      = PH_W'(ZERO_BIT);
    localparam logic [PH_W-1:0]  K_FWD_FIRST = PH_W'(FWD_FIRST);
    localparam logic [PH_W-1:0]  K_FWD_LAST  = PH_W'(FWD_LAST);

    typedef struct packed {
        seq_st_e             st;
        logic [PH_W-1:0]     ph;
        logic [GAP_W-1:0]    gap;
        logic [ADDR_LEN-1:0] addr;
        logic [DIV_W-1:0]    div;
        logic                share;
        logic                cs_n;
        logic                sclk;
        logic                di;
        logic                di_oe;
        logic                vld;
    } host_s;

    host_s d, q;

    logic            tick;
    logic            accept;
    logic            cap_shift;
    logic            cap_fwd;
    logic            cap_rev;
    logic [PH_W-1:0] k_cur;
    logic [PH_W-1:0] ph_inc;
    logic [PH_W-1:0] k_next;
    logic [7:0]      fwd_val;
    logic [7:0]      rev_val;

    sadc_halfclk #(.DIV_W(DIV_W)) i_halfclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (q.st == ST_IDLE),
        .half_len (q.div),
        .tick     (tick)
    );

    always_comb begin
        k_cur     = q.ph >> 1;
        ph_inc    = q.ph + 1'b1;
        k_next    = ph_inc >> 1;
        // rising edge happens at the end of every even (low) phase
        cap_shift = (q.st == ST_XFER) && tick && !q.ph[0] && (k_cur >= K_FWD_FIRST);
        cap_fwd   = (k_cur <= K_FWD_LAST);
        cap_rev   = (k_cur >= K_FWD_LAST);
    end

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        accept = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    d.st    = ST_XFER;
                    d.ph    = '0;
                    d.addr  = {1'b1, ~req_diff, req_odd, req_sel};
                    d.div   = div_half;
                    d.share = share_en;
                    d.cs_n  = 1'b0;
                    d.sclk  = 1'b0;
                    d.di    = 1'b1;
                    d.di_oe = 1'b1;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (!q.ph[0]) begin
                        d.ph   = ph_inc;
                        d.sclk = 1'b1;
                    end else if (q.ph == PH_LAST) begin
                        d.st    = ST_GAP;
                        d.gap   = '0;
                        d.cs_n  = 1'b1;
                        d.sclk  = 1'b1;
                        d.di    = 1'b0;
                        d.di_oe = 1'b1;
                        d.vld   = 1'b1;
                    end else begin
                        d.ph   = ph_inc;
                        d.sclk = 1'b0;
                        d.addr = {q.addr[ADDR_LEN-2:0], 1'b0};
                        if (k_next < K_ZERO) begin
                            d.di    = d.addr[ADDR_LEN-1];
                            d.di_oe = 1'b1;
                        end else begin
                            d.di    = 1'b0;
                            d.di_oe = ~q.share;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap == GAP_LAST) d.st  = ST_IDLE;
                    else                   d.gap = q.gap + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cs_n  <= 1'b1;
            q.sclk  <= 1'b1;
            q.di_oe <= 1'b1;
        end else begin
            q <= d;
        end
    end

    sadc_capture #(.W(RES_LEN)) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .shift  (cap_shift),
        .bit_in (adc_do),
        .to_fwd (cap_fwd),
        .to_rev (cap_rev),
        .fwd_o  (fwd_val),
        .rev_o  (rev_val)
    );

    assign req_ready    = (q.st == ST_IDLE);
    assign adc_cs_n     = q.cs_n;
    assign adc_sclk     = q.sclk;
    assign adc_di       = q.di;
    assign adc_di_oe    = q.di_oe;
    assign res_valid    = q.vld;
    assign res_data     = fwd_val;
    assign res_mismatch = (fwd_val != rev_val);

    // R7: converter reset condition, clock high while deselected
    a_r7_clk_high_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> q.sclk);

    // R7: chip select rises only out of a high clock phase
    a_r7_cs_rise_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_n) |-> $past(q.sclk));

    // R1: an accepted request selects the converter and blocks further requests
    a_r1_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!adc_cs_n && !req_ready));

    // R6: result strobe lasts one cycle and coincides with chip select rising
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r6_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_cs_n));

    // R3: data to the converter holds through every high clock phase
    a_r3_di_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cs_n && q.sclk && $past(q.sclk) && !$past(q.cs_n)) |-> $stable(q.di));

    // R8: once the shared line is released it stays released until deselect
    a_r8_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cs_n && q.share && !$past(q.di_oe)) |-> !q.di_oe);
endmodule

// File: tb/test_sadc_host.sv
`timescale 1ns/1ps
module test_sadc_host;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_sel = 2'd0;
    logic       req_odd = 1'b0;
    logic       req_diff = 1'b0;
    logic [7:0] div_half = 8'd25;
    logic       share_en = 1'b0;
    logic       adc_cs_n, adc_sclk, adc_di, adc_di_oe, adc_do;
    logic       res_valid;
    logic [7:0] res_data;
    logic       res_mismatch;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int exp_hl = 25;
    int salt = 7;
    logic m_corrupt = 1'b0;

    // converter model state
    logic       m_do = 1'b0;
    logic       prev_cs = 1'b1, prev_sclk = 1'b1;
    int         m_n = 0, m_last = 0;
    int         m_per_bad = 0, m_di_bad = 0, m_oe_bad = 0, m_cs_bad = 0;
    logic [4:0] m_addr = 5'd0;
    logic       m_di_hold = 1'b0;
    logic [7:0] m_val = 8'd0;

    always #10 clk = ~clk;

    assign adc_do = share_en ? (adc_di_oe ? adc_di : m_do) : m_do;

    sadc_host i_sadc_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_odd(req_odd), .req_diff(req_diff),
        .div_half(div_half), .share_en(share_en), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .adc_di(adc_di), .adc_di_oe(adc_di_oe),
        .adc_do(adc_do), .res_valid(res_valid), .res_data(res_data),
        .res_mismatch(res_mismatch)
    );

    function automatic logic [7:0] val_of(input logic [4:0] a);
        int v;
        v = int'(a) * 53 + salt;
        return v[7:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model, sampled between clock edges
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (prev_cs && !adc_cs_n) begin
                m_n = 0; m_addr = '0; m_per_bad = 0; m_di_bad = 0; m_oe_bad = 0; m_do = 1'b0;
            end
            if (adc_cs_n && !adc_sclk) m_cs_bad++;
            if (!adc_cs_n && !prev_cs && !prev_sclk && adc_sclk) begin
                m_n++;
                if (m_n > 1 && (cyc - m_last) != 2 * exp_hl) m_per_bad++;
                m_last = cyc;
                if (m_n <= 5) begin
                    m_addr = {m_addr[3:0], adc_di};
                    m_di_hold = adc_di;
                    if (!adc_di_oe) m_oe_bad++;
                end
                if (m_n == 5) m_val = val_of(m_addr);
                if (m_n >= 6) begin
                    if (share_en ? adc_di_oe : (!adc_di_oe || adc_di)) m_oe_bad++;
                end
            end else if (!adc_cs_n && adc_sclk && m_n >= 1 && m_n <= 5 && adc_di != m_di_hold) begin
                m_di_bad++;
            end
            if (!adc_cs_n && !prev_cs && prev_sclk && !adc_sclk) begin
                if ((cyc - m_last) != exp_hl) m_per_bad++;
                if (m_n >= 6 && m_n <= 13)       m_do = m_val[13 - m_n];
                else if (m_n >= 14 && m_n <= 20) m_do = m_val[m_n - 13] ^ (m_corrupt && (m_n - 13) == 3);
                else                             m_do = 1'b0;
            end
        end
        prev_cs = adc_cs_n;
        prev_sclk = adc_sclk;
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 190000) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    task automatic conv(input logic [1:0] sel, input logic odd, input logic diff,
                        input logic share, input logic [7:0] div,
                        input logic corrupt, input logic busy);
        logic [4:0] ea;
        logic [7:0] ev;
        logic [7:0] got;
        logic       mm;
        int         waitc;
        int         busy_bad;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        salt = salt + 29;
        req_sel = sel; req_odd = odd; req_diff = diff;
        share_en = share; div_half = div; m_corrupt = corrupt;
        exp_hl = (div == 0) ? 1 : int'(div);
        ea = {1'b1, ~diff, odd, sel};
        ev = val_of(ea);
        req_valid = 1'b1;
        @(negedge clk);
        chk(adc_cs_n == 1'b0 && req_ready == 1'b0, "R1 select after accept", int'(adc_cs_n), 0);
        if (busy) begin
            req_sel = ~sel; req_diff = ~diff; req_odd = ~odd; div_half = div + 8'd3;
        end else begin
            req_valid = 1'b0;
        end
        busy_bad = 0;
        while (!res_valid) begin
            @(negedge clk);
            if (req_ready) busy_bad++;
        end
        got = res_data; mm = res_mismatch;
        req_valid = 1'b0;
        chk(busy_bad == 0, "R1 ready low while busy", busy_bad, 0);
        chk(adc_cs_n == 1'b1, "R6 valid with deselect", int'(adc_cs_n), 1);
        chk(m_addr == ea, "R3 address word", int'(m_addr), int'(ea));
        chk(m_di_bad == 0, "R3 di stable high", m_di_bad, 0);
        chk(m_n == 21, "R2 rising edges", m_n, 21);
        chk(m_per_bad == 0, "R2 phase lengths", m_per_bad, 0);
        chk(got == ev, "R4 result data", int'(got), int'(ev));
        chk(mm == corrupt, "R5 mismatch flag", int'(mm), int'(corrupt));
        chk(m_oe_bad == 0, "R8 data line drive", m_oe_bad, 0);
        @(negedge clk);
        chk(res_valid == 1'b0, "R6 single pulse", int'(res_valid), 0);
        waitc = 1;
        while (!req_ready) begin
            @(negedge clk);
            waitc++;
        end
        chk(waitc == 2 * exp_hl, "R7 guard interval", waitc, 2 * exp_hl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R9 reset cs_n", int'(adc_cs_n), 1);
        chk(adc_sclk == 1'b1, "R9 reset sclk", int'(adc_sclk), 1);
        chk(res_valid == 1'b0, "R9 reset valid", int'(res_valid), 0);
        chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);

        // full address sweep in both wiring arrangements
        for (int sh = 0; sh < 2; sh++)
            for (int df = 0; df < 2; df++)
                for (int od = 0; od < 2; od++)
                    for (int s = 0; s < 4; s++)
                        conv(2'(s), 1'(od), 1'(df), 1'(sh), (sh == 0) ? 8'd25 : 8'd26, 1'b0, 1'b0);

        // R5 corrupted reversed copy, both arrangements
        conv(2'd1, 1'b1, 1'b0, 1'b0, 8'd25, 1'b1, 1'b0);
        conv(2'd2, 1'b0, 1'b1, 1'b1, 8'd25, 1'b1, 1'b0);
        // R1 request held during a running conversion
        conv(2'd3, 1'b0, 1'b0, 1'b0, 8'd25, 1'b0, 1'b1);
        conv(2'd0, 1'b1, 1'b1, 1'b1, 8'd25, 1'b0, 1'b1);
        // R2 divider corners
        conv(2'd2, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        conv(2'd1, 1'b0, 1'b1, 1'b1, 8'd1, 1'b0, 1'b0);
        conv(2'd3, 1'b1, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0);

        chk(m_cs_bad == 0, "R7 clock high while deselected", m_cs_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule